// File: doc/BRIEF.md
# Multi-Channel PWM Bank with Deferred Global Commit

This block generates pulse-width modulated waveforms on several independent output pins (four by default). Software programs it through a 32-bit word-addressed register bus with a single write strobe and a combinational read path. Each channel has a period value in clock ticks, a count of active ticks per period, a polarity bit and a mode field. The waveform is trailing-edge mark/space: the active part comes first in each period and the inactive part follows.

All per-channel settings are written into holding copies that leave the waveform unchanged. A single global request bit then commits every channel's holding copy into its running copy. An enabled channel commits only at the end of its current period, so no pulse is ever cut short or stretched. A disabled channel commits at once. The request bit reads back as set until every channel has committed, and then clears itself. The per-channel enable bits live in the global control word and take effect on the next clock.

Top module: `pwm_sync_bank`

## Requirements
- R1: After reset every output is low, the global word reads 0, every channel control word reads 0x00000101, and every period, phase and duty word reads 0.
- R2: Word addresses are decoded as follows. The global word is at 0x00, with channel n enabled by bit n and the commit request at bit 31. For channel n, control is at 0x14+0x10*n, period at 0x18+0x10*n, phase at 0x1C+0x10*n and duty at 0x20+0x10*n. The channel words read back the full 32 bits written. The global word reads back bits 3:0 and 31 and reads 0 elsewhere. Unaligned and unmapped addresses read 0, and writes to them change nothing.
- R3: An enabled channel counts from 0 to period-1 and then wraps. Before polarity, its output is active while the count is below duty.
- R4: A committed duty of 0 gives a constantly inactive output. A duty greater than or equal to the period gives a constantly active output.
- R5: Bit 3 of a committed control word inverts the channel output, so the active level becomes low and the idle level becomes high.
- R6: A channel whose enable bit is 0 drives its inactive level, which is its committed polarity bit. Its count restarts from 0 on the first cycle it is enabled.
- R7: Writes to the control, period or duty words do not change the output until a commit request is made.
- R8: After a commit request, an enabled channel takes its holding values on the clock edge that ends its current period. A disabled channel takes them on the next clock edge.
- R9: Bit 31 of the global word reads 1 from the request until every channel has committed, and then returns to 0. Writing 0 to bit 31 while a request is pending does not cancel it.
- R10: The mode field (control bits 1:0), control bit 8 and the phase word are stored and read back, but they have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 8 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
Short periods with duties below, equal to and above the period, plus duty 0, show the count bound and the saturation corners. Inverted channels, disabled channels and channels that are enabled while being re-programmed separate the polarity path from the enable path. Holding writes with no request, followed by a request, show whether a commit waits for the period boundary or leaks through early. A long-period channel with a cancel attempt shows whether the request bit stays pending. The run ends with a long random mix of writes to every mapped and unmapped word, with all outputs and the read data compared each cycle against a requirement-level model.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] GLB_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] CH_BASE  = 8'h14;

    localparam int UPD_BIT = 31;
    localparam int INV_BIT = 3;

    localparam logic [DATA_W-1:0] CTRL_RST = 32'h0000_0101;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_GLOBAL,
        RK_CTRL,
        RK_PERIOD,
        RK_PHASE,
        RK_DUTY
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] ch;
    } reg_sel_t;

    typedef struct packed {
        logic              inv;
        logic [DATA_W-1:0] period;
        logic [DATA_W-1:0] duty;
    } wave_cfg_t;

    // Map a byte address to a register kind and channel index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int nch);
        reg_sel_t          s;
        logic [ADDR_W-1:0] off;
        s.kind = RK_NONE;
        s.ch   = '0;
        off    = a - CH_BASE;
        if (a[1:0] == 2'b00) begin
            if (a == GLB_ADDR) begin
                s.kind = RK_GLOBAL;
            end else if (a >= CH_BASE && int'(off[7:4]) < nch) begin
                s.ch = off[7:4];
                case (off[3:2])
                    2'd0:    s.kind = RK_CTRL;
                    2'd1:    s.kind = RK_PERIOD;
                    2'd2:    s.kind = RK_PHASE;
                    default: s.kind = RK_DUTY;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_sync_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic                           upd_pending,
    output logic [NUM_CH-1:0]              chan_en,
    output logic                           req_set,
    output wave_cfg_t [NUM_CH-1:0]         shadow
);

    reg_sel_t          sel;
    logic [DATA_W-1:0] ctrl_q   [NUM_CH];
    logic [DATA_W-1:0] period_q [NUM_CH];
    logic [DATA_W-1:0] phase_q  [NUM_CH];
    logic [DATA_W-1:0] duty_q   [NUM_CH];
    logic [NUM_CH-1:0] en_q;

    always_comb sel = decode_addr(bus_addr, NUM_CH);

    assign req_set = bus_wr && (sel.kind == RK_GLOBAL) && bus_wdata[UPD_BIT];
    assign chan_en = en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bus_wr && sel.kind == RK_GLOBAL) begin
            en_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan_regs
        logic hit;
        assign hit = bus_wr && (sel.ch == 4'(n));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[n]   <= CTRL_RST;
                period_q[n] <= '0;
                phase_q[n]  <= '0;
                duty_q[n]   <= '0;
            end else if (hit) begin
                case (sel.kind)
                    RK_CTRL:   ctrl_q[n]   <= bus_wdata;
                    RK_PERIOD: period_q[n] <= bus_wdata;
                    RK_PHASE:  phase_q[n]  <= bus_wdata;
                    RK_DUTY:   duty_q[n]   <= bus_wdata;
                    default:   ;
                endcase
            end
        end

        assign shadow[n].inv    = ctrl_q[n][INV_BIT];
        assign shadow[n].period = period_q[n];
        assign shadow[n].duty   = duty_q[n];
    end

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            RK_GLOBAL: begin
                bus_rdata[NUM_CH-1:0] = en_q;
                bus_rdata[UPD_BIT]    = upd_pending;
            end
            RK_CTRL, RK_PERIOD, RK_PHASE, RK_DUTY: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    if (sel.ch == 4'(n)) begin
                        case (sel.kind)
                            RK_CTRL:   bus_rdata = ctrl_q[n];
                            RK_PERIOD: bus_rdata = period_q[n];
                            RK_PHASE:  bus_rdata = phase_q[n];
                            default:   bus_rdata = duty_q[n];
                        endcase
                    end
                end
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_commit_ctrl.sv
module pwm_commit_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_set,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] chan_wrap,
    output logic [NUM_CH-1:0] chan_load,
    output logic              upd_pending
);

    logic              pending_q;
    logic [NUM_CH-1:0] done_q;
    logic [NUM_CH-1:0] done_nx;

    // A channel commits once per request: at once when idle, at its wrap when running.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_load
        assign chan_load[n] = pending_q && !done_q[n] && (!chan_en[n] || chan_wrap[n]);
    end

    assign done_nx     = done_q | chan_load;
    assign upd_pending = pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            done_q    <= '0;
        end else if (req_set) begin
            pending_q <= 1'b1;
            done_q    <= '0;
        end else if (pending_q && (&done_nx)) begin
            pending_q <= 1'b0;
            done_q    <= '0;
        end else begin
            done_q    <= done_nx;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      load,
    input  wave_cfg_t shadow,
    output logic      wrap,
    output logic      mark,
    output logic      inv
);

    wave_cfg_t         act_q;
    logic [DATA_W-1:0] cnt_q;

    assign wrap = (act_q.period == '0) || (cnt_q == act_q.period - 1'b1);
    assign mark = enable && (cnt_q < act_q.duty);
    assign inv  = act_q.inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (load) begin
            act_q <= shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_sync_bank.sv
module pwm_sync_bank
    import pwm_sync_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CH-1:0]    pwm_out
);

    logic                  req_set;
    logic                  upd_pending;
    logic [NUM_CH-1:0]     chan_en;
    logic [NUM_CH-1:0]     chan_wrap;
    logic [NUM_CH-1:0]     chan_load;
    logic [NUM_CH-1:0]     chan_mark;
    logic [NUM_CH-1:0]     chan_inv;
    wave_cfg_t [NUM_CH-1:0] shadow;

    pwm_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .upd_pending (upd_pending),
        .chan_en     (chan_en),
        .req_set     (req_set),
        .shadow      (shadow)
    );

    pwm_commit_ctrl #(.NUM_CH(NUM_CH)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .req_set     (req_set),
        .chan_en     (chan_en),
        .chan_wrap   (chan_wrap),
        .chan_load   (chan_load),
        .upd_pending (upd_pending)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_channel u_chan (
            .clk    (clk),
            .rst    (rst),
            .enable (chan_en[n]),
            .load   (chan_load[n]),
            .shadow (shadow[n]),
            .wrap   (chan_wrap[n]),
            .mark   (chan_mark[n]),
            .inv    (chan_inv[n])
        );
        assign pwm_out[n] = chan_mark[n] ^ chan_inv[n];
    end

endmodule

// File: rtl/pwm_sync_bank_chk.sv
module pwm_sync_bank_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] chan_inv,
    input logic [NUM_CH-1:0] chan_load,
    input logic              upd_pending
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (rst)
            !chan_en[n] |-> pwm_out[n] == chan_inv[n]); // R6

        AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
            chan_load[n] |-> upd_pending); // R8

        AST_INV_HELD: assert property (@(posedge clk) disable iff (rst)
            !chan_load[n] |=> $stable(chan_inv[n])); // R7
    end

    AST_REQ_CLEARS_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pending) |-> $past(|chan_load)); // R9

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (upd_pending && !(|chan_load)) |=> upd_pending); // R9

endmodule

bind pwm_sync_bank pwm_sync_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwm_out     (pwm_out),
    .chan_en     (chan_en),
    .chan_inv    (chan_inv),
    .chan_load   (chan_load),
    .upd_pending (upd_pending)
);

// File: tb/tb_pwm_sync_bank.sv
module tb_pwm_sync_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    pwm_sync_bank dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- requirement-level reference model ----------------
    logic [31:0] m_ctrl [NCH];
    logic [31:0] m_per  [NCH];
    logic [31:0] m_pha  [NCH];
    logic [31:0] m_duty [NCH];
    logic [31:0] m_aper [NCH];
    logic [31:0] m_aduty[NCH];
    logic [31:0] m_cnt  [NCH];
    logic        m_ainv [NCH];
    logic [3:0]  m_en;
    logic        m_pend;
    logic [3:0]  m_done;
    logic [3:0]  m_ld;
    logic [3:0]  m_dn;

    // Channel index and word kind (0 ctrl, 1 period, 2 phase, 3 duty); -1 when not a channel word.
    function automatic int ch_of(input logic [7:0] a);
        int off;
        if (a[1:0] != 2'b00 || a < 8'h14 || a > 8'h50) return -1;
        off = int'(a) - 'h14;
        return off / 16;
    endfunction

    function automatic int kind_of(input logic [7:0] a);
        return ((int'(a) - 'h14) % 16) / 4;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int c;
        if (a == 8'h00) return {m_pend, 27'd0, m_en};
        c = ch_of(a);
        if (c < 0) return 32'd0;
        case (kind_of(a))
            0: return m_ctrl[c];
            1: return m_per[c];
            2: return m_pha[c];
            default: return m_duty[c];
        endcase
    endfunction

    function automatic logic [3:0] m_out();
        logic [3:0] o;
        for (int n = 0; n < NCH; n++)
            o[n] = m_en[n] ? ((m_cnt[n] < m_aduty[n]) ^ m_ainv[n]) : m_ainv[n];
        return o;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NCH; n++) begin
                m_ctrl[n] <= 32'h101; m_per[n] <= 0; m_pha[n] <= 0; m_duty[n] <= 0;
                m_aper[n] <= 0; m_aduty[n] <= 0; m_cnt[n] <= 0; m_ainv[n] <= 0;
            end
            m_en <= 0; m_pend <= 0; m_done <= 0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                logic w;
                w = (m_aper[n] == 0) || (m_cnt[n] == m_aper[n] - 1);
                m_ld[n] = m_pend && !m_done[n] && (!m_en[n] || w);
                if (m_ld[n]) begin
                    m_aper[n] <= m_per[n]; m_aduty[n] <= m_duty[n]; m_ainv[n] <= m_ctrl[n][3];
                end
                m_cnt[n] <= (!m_en[n] || w) ? 32'd0 : m_cnt[n] + 1;
            end
            m_dn = m_done | m_ld;
            if (bus_wr && bus_addr == 8'h00 && bus_wdata[31]) begin
                m_pend <= 1; m_done <= 0;
            end else if (m_pend && (&m_dn)) begin
                m_pend <= 0; m_done <= 0;
            end else begin
                m_done <= m_dn;
            end
            if (bus_wr) begin
                if (bus_addr == 8'h00) m_en <= bus_wdata[3:0];
                else if (ch_of(bus_addr) >= 0) begin
                    case (kind_of(bus_addr))
                        0: m_ctrl[ch_of(bus_addr)] <= bus_wdata;
                        1: m_per [ch_of(bus_addr)] <= bus_wdata;
                        2: m_pha [ch_of(bus_addr)] <= bus_wdata;
                        default: m_duty[ch_of(bus_addr)] <= bus_wdata;
                    endcase
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (cmp_on && !rst && !finished) begin
            check(pwm_out == m_out(), cur_tag, {28'd0, pwm_out}, {28'd0, m_out()});
            check(bus_rdata == m_read(bus_addr), "R2 read", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1 hi += pwm_out[ch];
        end
    endtask

    function automatic logic [7:0] ca(input int ch, input int k);
        return 8'(8'h14 + 16 * ch + 4 * k);
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        int          hi;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R1: reset state
        cur_tag = "R1";
        check(pwm_out == 4'h0, "R1 outputs", {28'd0, pwm_out}, 32'd0);
        for (int a = 0; a < 'h60; a += 4) begin
            rd(8'(a), v);
            check(v == ((ch_of(8'(a)) >= 0 && kind_of(8'(a)) == 0) ? 32'h101 : 32'h0), "R1 read", v,
                  (ch_of(8'(a)) >= 0 && kind_of(8'(a)) == 0) ? 32'h101 : 32'h0);
        end

        // R2: readback and unmapped addresses
        cur_tag = "R2";
        wr(ca(3, 2), 32'hA5A5_1234);
        rd(ca(3, 2), v);   check(v == 32'hA5A5_1234, "R2 phase readback", v, 32'hA5A5_1234);
        wr(8'h15, 32'hFFFF_FFFF);
        rd(ca(0, 0), v);   check(v == 32'h101, "R2 unaligned write ignored", v, 32'h101);
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, v);      check(v == 32'h0, "R2 unmapped read", v, 32'h0);
        wr(8'h54, 32'h1234_5678);
        rd(8'h54, v);      check(v == 32'h0, "R2 unmapped high read", v, 32'h0);
        wr(8'h00, 32'h0000_0FF0);
        rd(8'h00, v);      check(v == 32'h0, "R2 global reserved bits", v, 32'h0);
        wr(ca(3, 2), 32'h0);

        // R3: ch0 period 5 duty 2 -> 4 active of 10
        cur_tag = "R3";
        wr(ca(0, 1), 5); wr(ca(0, 3), 2);
        wr(8'h00, 32'h8000_0000); idle(2);
        wr(8'h00, 32'h1);
        count_high(0, 10, hi); check(hi == 4, "R3 mark count", hi, 4);

        // R4: ch1 duty above period and duty 0
        cur_tag = "R4";
        wr(ca(1, 1), 3); wr(ca(1, 3), 7);
        wr(8'h00, 32'h8000_0001); idle(6);
        wr(8'h00, 32'h3);
        count_high(1, 9, hi); check(hi == 9, "R4 saturated high", hi, 9);
        wr(ca(1, 3), 0);
        wr(8'h00, 32'h8000_0003); idle(6);
        count_high(1, 9, hi); check(hi == 0, "R4 duty zero", hi, 0);

        // R5: inverted ch2 period 4 duty 1
        cur_tag = "R5";
        wr(ca(2, 0), 32'h109); wr(ca(2, 1), 4); wr(ca(2, 3), 1);
        wr(8'h00, 32'h8000_0003); idle(6);
        wr(8'h00, 32'h7);
        count_high(2, 8, hi); check(hi == 6, "R5 inverted count", hi, 6);

        // R6: disabled inverted channel idles high
        cur_tag = "R6";
        wr(8'h00, 32'h3);
        count_high(2, 8, hi); check(hi == 8, "R6 disabled idle level", hi, 8);

        // R7: holding write without a request
        cur_tag = "R7";
        wr(ca(0, 3), 4);
        count_high(0, 10, hi); check(hi == 4, "R7 no early effect", hi, 4);

        // R8: request commits at the boundary
        cur_tag = "R8";
        wr(8'h00, 32'h8000_0003); idle(6);
        count_high(0, 10, hi); check(hi == 8, "R8 committed duty", hi, 8);

        // R10: mode, bit 8 and phase do not alter the waveform
        cur_tag = "R10";
        wr(ca(0, 0), 32'h0000_0002); wr(ca(0, 2), 32'h3);
        wr(8'h00, 32'h8000_0003); idle(6);
        count_high(0, 10, hi); check(hi == 8, "R10 mode ignored", hi, 8);
        rd(ca(0, 0), v); check(v == 32'h2, "R10 ctrl readback", v, 32'h2);

        // R9: pending bit holds against a cancel attempt
        cur_tag = "R9";
        wr(ca(3, 1), 60); wr(ca(3, 3), 30);
        wr(8'h00, 32'h8000_0000); idle(3);
        wr(8'h00, 32'h8);
        wr(8'h00, 32'h8000_0008);
        rd(8'h00, v); check(v == 32'h8000_0008, "R9 pending set", v, 32'h8000_0008);
        wr(8'h00, 32'h0000_0008);
        rd(8'h00, v); check(v == 32'h8000_0008, "R9 cancel ignored", v, 32'h8000_0008);
        idle(70);
        rd(8'h00, v); check(v == 32'h0000_0008, "R9 self clear", v, 32'h0000_0008);

        // Random mix, outputs and reads compared each cycle
        cur_tag = "R3/R8 random";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            bus_addr = 8'($urandom_range(0, 23) * 4);
            if ($urandom_range(0, 3) == 0) begin
                bus_wr = 1'b1;
                case ($urandom_range(0, 4))
                    0: begin bus_addr = 8'h00; bus_wdata = {1'($urandom_range(0, 1)), 27'($urandom), 4'($urandom)}; end
                    1: begin bus_addr = ca($urandom_range(0, 3), 1); bus_wdata = $urandom_range(0, 7); end
                    2: begin bus_addr = ca($urandom_range(0, 3), 3); bus_wdata = $urandom_range(0, 9); end
                    3: begin bus_addr = ca($urandom_range(0, 3), 0); bus_wdata = $urandom; end
                    default: begin bus_addr = 8'($urandom); bus_wdata = $urandom; end
                endcase
            end
        end
        @(negedge clk); bus_wr = 1'b0;
        idle(4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule